// File: doc/BRIEF.md
# Idle Clock Gating Controller

This controller decides, cycle by cycle, whether the processor core of a small microcontroller receives a clock, whether the peripherals receive one, and which oscillator feeds them. Software enables idling with a control bit and then issues a sleep strobe. The two-bit source select chooses the idle flavour. In the primary flavour the main oscillator keeps running and only the core is stopped. In the secondary flavour the low-rate secondary oscillator drives the peripherals, and the main oscillator is switched off.

A wake event ends idling. The core clock stays gated for a fixed number of cycles and then resumes from the same source that the peripherals were using. The sleep request is qualified first. A request for the secondary source while its oscillator is disabled is dropped, and so is any request that would need full sleep or a reserved select code. The control inputs belong to software and the block never writes them.

The states are ST_PRI_RUN, ST_SEC_RUN, ST_PRI_IDLE, ST_SEC_IDLE, ST_PRI_WAKE and ST_SEC_WAKE. The transitions are:
- enter_pri: either run state goes to ST_PRI_IDLE.
- enter_sec: either run state goes to ST_SEC_IDLE.
- wake_pri: ST_PRI_IDLE goes to ST_PRI_WAKE.
- wake_sec: ST_SEC_IDLE goes to ST_SEC_WAKE.
- resume_pri: ST_PRI_WAKE goes to ST_PRI_RUN when the delay expires.
- resume_sec: ST_SEC_WAKE goes to ST_SEC_RUN when the delay expires.

Top module: `idlegate_ctrl`

## Requirements
- R1: During and after reset, `mode` is 2'b00 (primary run). `cpu_clk_en`, `per_clk_en`, `pri_osc_en` and `pri_stable` are 1, and `per_src_sec` and `sec_active` are 0.
- R2: In a run state, a cycle with `sleep_req`=1, `idle_en`=1 and `clk_sel`=2'b00 moves the block to primary idle at the next clock. Primary idle means `mode`=2'b10, `cpu_clk_en`=0, `per_clk_en`=1, `per_src_sec`=0, `pri_osc_en`=1 and `pri_stable`=1.
- R3: In a run state, a cycle with `sleep_req`=1, `idle_en`=1, `clk_sel`=2'b01 and `sec_osc_en`=1 moves the block to secondary idle at the next clock. Secondary idle means `mode`=2'b11, `cpu_clk_en`=0, `per_src_sec`=1, `pri_osc_en`=0, `pri_stable`=0 and `sec_active`=1.
- R4: A sleep strobe is ignored and every output stays unchanged in three cases: `idle_en`=0, `clk_sel` of 2'b10 or 2'b11, or `clk_sel`=2'b01 with `sec_osc_en`=0.
- R5: While the secondary source is selected (`per_src_sec`=1), `per_clk_en` equals `sec_osc_ready`. It is held low until the running flag is high.
- R6: A wake event sampled in an idle state keeps `cpu_clk_en` low for exactly WAKE_DLY further clock cycles (default 4). During that time `mode` keeps its idle code. `cpu_clk_en` then rises.
- R7: After waking, the core resumes from the peripheral source. Primary idle returns to `mode`=2'b00. Secondary idle returns to `mode`=2'b01, with `sec_active`=1 and `pri_osc_en`=0 kept.
- R8: A wake event sampled in a run state has no effect.
- R9: A sleep strobe sampled during the wake delay is ignored and does not change the resume cycle.
- R10: From secondary run, a qualified request with `clk_sel`=2'b00 enters primary idle and sets `pri_osc_en`, `pri_stable` to 1 and `sec_active` to 0. A qualified request with 2'b01 enters secondary idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the active source |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep_req | input | 1 | One-cycle sleep instruction strobe |
| idle_en | input | 1 | Idle-instead-of-sleep control bit |
| clk_sel | input | 2 | Clock source select, 2'b00 primary, 2'b01 secondary |
| sec_osc_en | input | 1 | Secondary oscillator enable bit |
| sec_osc_ready | input | 1 | Secondary oscillator running flag |
| wake_evt | input | 1 | Wake event |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| per_src_sec | output | 1 | Peripheral clock source, 1 selects secondary |
| pri_osc_en | output | 1 | Primary oscillator enable |
| pri_stable | output | 1 | Primary oscillator stable flag |
| sec_active | output | 1 | Secondary oscillator is the active source |
| mode | output | 2 | 00 primary run, 01 secondary run, 10 primary idle, 11 secondary idle |

## Verification
The assertions assume that all inputs are synchronous to `clk` and are sampled once per rising edge. Sleep and wake are treated as level samples, so holding either one for several cycles counts as a new strobe in each cycle. They also assume that `clk` is the clock of whichever source is active, so the wake delay is counted in plain cycles. The bench changes every input only on the falling edge. It draws the random values each cycle from a fixed seed, so strobes land in run, idle and wake states alike while all timing stays inside the assumed synchronous window.

// File: rtl/idlegate_pkg.sv
package idlegate_pkg;

    typedef enum logic [2:0] {
        ST_PRI_RUN,
        ST_SEC_RUN,
        ST_PRI_IDLE,
        ST_SEC_IDLE,
        ST_PRI_WAKE,
        ST_SEC_WAKE
    } gate_state_e;

    localparam logic [1:0] SEL_PRI = 2'b00;
    localparam logic [1:0] SEL_SEC = 2'b01;

    localparam logic [1:0] MODE_PRI_RUN  = 2'b00;
    localparam logic [1:0] MODE_SEC_RUN  = 2'b01;
    localparam logic [1:0] MODE_PRI_IDLE = 2'b10;
    localparam logic [1:0] MODE_SEC_IDLE = 2'b11;

    typedef struct packed {
        logic       cpu_en;
        logic       per_sec;
        logic       pri_on;
        logic [1:0] mode;
    } gate_ctl_t;

endpackage

// File: rtl/idlegate_wake_timer.sv
module idlegate_wake_timer #(
    parameter int WAKE_DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic done
);
    localparam int CW = (WAKE_DLY < 2) ? 1 : $clog2(WAKE_DLY);
    localparam logic [CW-1:0] LOAD_VAL = CW'(WAKE_DLY - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/idlegate_sleep_qual.sv
module idlegate_sleep_qual
    import idlegate_pkg::*;
(
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic [1:0] clk_sel,
    input  logic       sec_osc_en,
    output logic       go_pri_idle,
    output logic       go_sec_idle
);
    logic want_idle;

    always_comb begin
        want_idle   = sleep_req && idle_en;
        go_pri_idle = 1'b0;
        go_sec_idle = 1'b0;
        unique case (clk_sel)
            SEL_PRI: go_pri_idle = want_idle;
            SEL_SEC: go_sec_idle = want_idle && sec_osc_en;
            default: begin
                go_pri_idle = 1'b0;
                go_sec_idle = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/idlegate_out_dec.sv
module idlegate_out_dec
    import idlegate_pkg::*;
(
    input  gate_state_e state,
    input  logic        sec_osc_ready,
    output logic        cpu_clk_en,
    output logic        per_clk_en,
    output logic        per_src_sec,
    output logic        pri_osc_en,
    output logic        pri_stable,
    output logic        sec_active,
    output logic [1:0]  mode
);
    gate_ctl_t ctl;

    always_comb begin
        ctl = '0;
        unique case (state)
            ST_PRI_RUN:  ctl = '{cpu_en: 1'b1, per_sec: 1'b0, pri_on: 1'b1, mode: MODE_PRI_RUN};
            ST_SEC_RUN:  ctl = '{cpu_en: 1'b1, per_sec: 1'b1, pri_on: 1'b0, mode: MODE_SEC_RUN};
            ST_PRI_IDLE,
            ST_PRI_WAKE: ctl = '{cpu_en: 1'b0, per_sec: 1'b0, pri_on: 1'b1, mode: MODE_PRI_IDLE};
            ST_SEC_IDLE,
            ST_SEC_WAKE: ctl = '{cpu_en: 1'b0, per_sec: 1'b1, pri_on: 1'b0, mode: MODE_SEC_IDLE};
            default:     ctl = '{cpu_en: 1'b1, per_sec: 1'b0, pri_on: 1'b1, mode: MODE_PRI_RUN};
        endcase
    end

    assign cpu_clk_en  = ctl.cpu_en;
    assign per_src_sec = ctl.per_sec;
    assign pri_osc_en  = ctl.pri_on;
    assign pri_stable  = ctl.pri_on;
    assign sec_active  = ctl.per_sec;
    assign mode        = ctl.mode;
    assign per_clk_en  = ctl.per_sec ? sec_osc_ready : 1'b1;

endmodule

// File: rtl/idlegate_ctrl.sv
module idlegate_ctrl
    import idlegate_pkg::*;
#(
    parameter int WAKE_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       idle_en,
    input  logic [1:0] clk_sel,
    input  logic       sec_osc_en,
    input  logic       sec_osc_ready,
    input  logic       wake_evt,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       per_src_sec,
    output logic       pri_osc_en,
    output logic       pri_stable,
    output logic       sec_active,
    output logic [1:0] mode
);
    gate_state_e state_q, state_d;
    logic        go_pri_idle, go_sec_idle;
    logic        wake_load, wake_tick, wake_done;

    idlegate_sleep_qual i_qual (
        .sleep_req   (sleep_req),
        .idle_en     (idle_en),
        .clk_sel     (clk_sel),
        .sec_osc_en  (sec_osc_en),
        .go_pri_idle (go_pri_idle),
        .go_sec_idle (go_sec_idle)
    );

    idlegate_wake_timer #(.WAKE_DLY(WAKE_DLY)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (wake_load),
        .tick  (wake_tick),
        .done  (wake_done)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRI_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and timer control
    always_comb begin
        state_d   = state_q;
        wake_load = 1'b0;
        wake_tick = 1'b0;
        unique case (state_q)
            ST_PRI_RUN, ST_SEC_RUN: begin
                if (go_pri_idle)      state_d = ST_PRI_IDLE;   // enter_pri
                else if (go_sec_idle) state_d = ST_SEC_IDLE;   // enter_sec
            end
            ST_PRI_IDLE: begin
                if (wake_evt) begin                            // wake_pri
                    state_d   = ST_PRI_WAKE;
                    wake_load = 1'b1;
                end
            end
            ST_SEC_IDLE: begin
                if (wake_evt) begin                            // wake_sec
                    state_d   = ST_SEC_WAKE;
                    wake_load = 1'b1;
                end
            end
            ST_PRI_WAKE: begin
                wake_tick = 1'b1;
                if (wake_done) state_d = ST_PRI_RUN;           // resume_pri
            end
            ST_SEC_WAKE: begin
                wake_tick = 1'b1;
                if (wake_done) state_d = ST_SEC_RUN;           // resume_sec
            end
            default: state_d = ST_PRI_RUN;
        endcase
    end

    idlegate_out_dec i_dec (
        .state         (state_q),
        .sec_osc_ready (sec_osc_ready),
        .cpu_clk_en    (cpu_clk_en),
        .per_clk_en    (per_clk_en),
        .per_src_sec   (per_src_sec),
        .pri_osc_en    (pri_osc_en),
        .pri_stable    (pri_stable),
        .sec_active    (sec_active),
        .mode          (mode)
    );

endmodule

// File: rtl/idlegate_ctrl_chk.sv
module idlegate_ctrl_chk #(
    parameter int WAKE_DLY = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sleep_req,
    input logic       idle_en,
    input logic [1:0] clk_sel,
    input logic       sec_osc_en,
    input logic       sec_osc_ready,
    input logic       wake_evt,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       per_src_sec,
    input logic       pri_osc_en,
    input logic       pri_stable,
    input logic       sec_active,
    input logic [1:0] mode
);
    logic        waking;
    int unsigned wcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            waking <= 1'b0;
            wcnt   <= 0;
        end else if (!waking && !cpu_clk_en && wake_evt) begin
            waking <= 1'b1;
            wcnt   <= 0;
        end else if (waking) begin
            if (cpu_clk_en) waking <= 1'b0;
            else            wcnt   <= wcnt + 1;
        end
    end

    assert_pri_idle_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sleep_req && idle_en && clk_sel == 2'b00)
        |=> (mode == 2'b10 && !cpu_clk_en && per_clk_en && pri_osc_en && pri_stable));

    assert_sec_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_active |-> (!pri_osc_en && !pri_stable && per_src_sec));

    assert_sec_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && sleep_req && clk_sel == 2'b01 && !sec_osc_en)
        |=> (cpu_clk_en && mode == $past(mode)));

    assert_per_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (per_src_sec && !sec_osc_ready) |-> !per_clk_en);

    assert_wake_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (waking && wcnt == WAKE_DLY));

    assert_resume_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_clk_en) |-> (mode[0] == $past(mode[0])));

    assert_run_wake_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_clk_en && !(sleep_req && idle_en)) |=> cpu_clk_en);

endmodule

bind idlegate_ctrl idlegate_ctrl_chk #(.WAKE_DLY(WAKE_DLY)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sleep_req     (sleep_req),
    .idle_en       (idle_en),
    .clk_sel       (clk_sel),
    .sec_osc_en    (sec_osc_en),
    .sec_osc_ready (sec_osc_ready),
    .wake_evt      (wake_evt),
    .cpu_clk_en    (cpu_clk_en),
    .per_clk_en    (per_clk_en),
    .per_src_sec   (per_src_sec),
    .pri_osc_en    (pri_osc_en),
    .pri_stable    (pri_stable),
    .sec_active    (sec_active),
    .mode          (mode)
);

// File: tb/test_idlegate_ctrl.sv
`timescale 1ns/1ps
module test_idlegate_ctrl;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, idle_en = 1'b0, sec_osc_en = 1'b0;
    logic       sec_osc_ready = 1'b0, wake_evt = 1'b0;
    logic [1:0] clk_sel = 2'b00;
    logic       cpu_clk_en, per_clk_en, per_src_sec, pri_osc_en, pri_stable, sec_active;
    logic [1:0] mode;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // Reference state derived from the requirements
    bit m_idle, m_sec;
    int m_wcnt;

    always #2.5 clk = ~clk;

    idlegate_ctrl #(.WAKE_DLY(D)) i_idlegate_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .idle_en(idle_en),
        .clk_sel(clk_sel), .sec_osc_en(sec_osc_en), .sec_osc_ready(sec_osc_ready),
        .wake_evt(wake_evt), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .per_src_sec(per_src_sec), .pri_osc_en(pri_osc_en), .pri_stable(pri_stable),
        .sec_active(sec_active), .mode(mode)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idle <= 1'b0; m_sec <= 1'b0; m_wcnt <= 0;
        end else if (!m_idle) begin
            if (sleep_req && idle_en && clk_sel == 2'b00) begin
                m_idle <= 1'b1; m_sec <= 1'b0;
            end else if (sleep_req && idle_en && clk_sel == 2'b01 && sec_osc_en) begin
                m_idle <= 1'b1; m_sec <= 1'b1;
            end
        end else if (m_wcnt > 0) begin
            if (m_wcnt == 1) m_idle <= 1'b0;
            m_wcnt <= m_wcnt - 1;
        end else if (wake_evt) begin
            m_wcnt <= D;
        end
    end

    function automatic logic [1:0] exp_mode();
        return {m_idle, m_sec};
    endfunction

    function automatic logic exp_per();
        return m_sec ? sec_osc_ready : 1'b1;
    endfunction

    task automatic cmp(input string tag, input string nm, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        cmp(tag, "mode", mode, exp_mode());
        cmp(tag, "cpu_clk_en", {1'b0, cpu_clk_en}, {1'b0, !m_idle});
        cmp(tag, "per_clk_en", {1'b0, per_clk_en}, {1'b0, exp_per()});
        cmp(tag, "per_src_sec", {1'b0, per_src_sec}, {1'b0, m_sec});
        cmp(tag, "pri_osc_en", {1'b0, pri_osc_en}, {1'b0, !m_sec});
        cmp(tag, "pri_stable", {1'b0, pri_stable}, {1'b0, !m_sec});
        cmp(tag, "sec_active", {1'b0, sec_active}, {1'b0, m_sec});
    endtask

    // Drive at falling edge, then check at the next falling edge
    task automatic cyc(input string tag, input logic slp, input logic ien, input logic [1:0] sel,
                       input logic sen, input logic rdy, input logic wk);
        sleep_req = slp; idle_en = ien; clk_sel = sel;
        sec_osc_en = sen; sec_osc_ready = rdy; wake_evt = wk;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after reset");

        // R4: rejected requests
        cyc("R4 idle_en low", 1, 0, 2'b00, 1, 1, 0);
        cyc("R4 sec not enabled", 1, 1, 2'b01, 0, 1, 0);
        cyc("R4 reserved select 10", 1, 1, 2'b10, 1, 1, 0);
        cyc("R4 reserved select 11", 1, 1, 2'b11, 1, 1, 0);
        // R2: primary idle and stay there
        cyc("R2 enter primary idle", 1, 1, 2'b00, 0, 0, 0);
        cyc("R2 hold primary idle", 0, 1, 2'b00, 0, 0, 0);
        // R6: wake delay from primary idle
        cyc("R6 wake captured", 0, 1, 2'b00, 0, 0, 1);
        for (int k = 0; k < D; k++) cyc("R6 wake delay", 0, 1, 2'b00, 0, 0, 0);
        if (!cpu_clk_en) begin
            failures++;
            $display("FAIL R7 cpu_clk_en actual=0 expected=1");
        end
        checks++;
        // R8: wake while running
        cyc("R8 wake in run", 0, 1, 2'b00, 0, 0, 1);
        cyc("R8 after wake in run", 0, 1, 2'b00, 0, 0, 0);
        // R3 / R5: secondary idle with oscillator not yet running
        cyc("R3 enter secondary idle", 1, 1, 2'b01, 1, 0, 0);
        cyc("R5 per clock held", 0, 1, 2'b01, 1, 0, 0);
        cyc("R5 oscillator running", 0, 1, 2'b01, 1, 1, 0);
        // R9: sleep during wake delay
        cyc("R9 wake captured", 0, 1, 2'b01, 1, 1, 1);
        cyc("R9 sleep in delay", 1, 1, 2'b00, 1, 1, 0);
        for (int k = 1; k < D; k++) cyc("R9 delay continues", 1, 1, 2'b01, 1, 1, 0);
        cyc("R7 secondary run", 0, 1, 2'b01, 1, 1, 0);
        if (mode !== 2'b01) begin
            failures++;
            $display("FAIL R7 mode actual=%0b expected=01", mode);
        end
        checks++;
        // R10: secondary run to primary idle, and back round to secondary idle
        cyc("R10 sec run to pri idle", 1, 1, 2'b00, 1, 1, 0);
        cyc("R10 wake", 0, 1, 2'b00, 1, 1, 1);
        for (int k = 0; k < D; k++) cyc("R10 delay", 0, 1, 2'b00, 1, 1, 0);
        cyc("R10 pri run to sec idle", 1, 1, 2'b01, 1, 1, 0);
        cyc("R10 wake", 0, 1, 2'b01, 1, 1, 1);
        for (int k = 0; k < D; k++) cyc("R10 delay", 0, 1, 2'b01, 1, 1, 0);
        cyc("R10 sec run to sec idle", 1, 1, 2'b01, 1, 1, 0);

        // Constrained random phase, fixed seed
        void'($urandom(32'd1234));
        for (int n = 0; n < 4000; n++) begin
            logic slp, ien, sen, rdy, wk;
            logic [1:0] sel;
            slp = ($urandom % 4) == 0;
            ien = ($urandom % 5) != 0;
            sel = (($urandom % 8) == 0) ? 2'($urandom) : {1'b0, 1'($urandom)};
            sen = ($urandom % 4) != 0;
            rdy = ($urandom % 6) != 0;
            wk  = ($urandom % 6) == 0;
            cyc("R2 R3 R4 R5 R6 R7 R8 R9 random", slp, ien, sel, sen, rdy, wk);
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule